// File: doc/BRIEF.md
# Head Stepping Command Sequencer

This block carries out the head-positioning commands of a floppy disk controller. It can return the head to track zero, move it to a target track, or move it by a single step. A single step goes inward, goes outward, or repeats the last direction. The block drives the step pulse and the direction level to the drive. It keeps the track register and raises the interrupt request when a command finishes.

The block controls head engagement, which depends on the head-load and verify option bits. It releases the head by itself when the controller has been idle for a set number of index pulses. Track verification is not done here. When verification is requested, the block raises `verify_req` after stepping and waits for `verify_done` together with a pass/fail level.

The block accepts a command through a single-cycle `cmd_valid` strobe, and only while it is idle. The same block runs the command logic for every command code. Step spacing is counted in cycles of an external `tick` input, so the real-time delays can be scaled. Step pulse width is counted in clock cycles and depends on the density select.

Top module: `head_step_seq`

## Requirements
- R1: After reset, busy, intrq, step_out, hld_out, dir_out, seek_err, verify_req and track are all 0. While idle, `trk_wr` loads `trk_wdata` into the track register.
- R2: Restore (cmd_op=0) with `trk0_n` already low issues no step, clears the track register to 0 and raises intrq.
- R3: Restore with `trk0_n` high issues outward steps (dir_out=0) until `trk0_n` goes low, then clears the track register to 0 and raises intrq.
- R4: If `trk0_n` has not gone low after exactly 255 restore steps, restore ends with seek_err=1 and raises intrq. The track register is left unchanged.
- R5: Seek (cmd_op=1) steps toward `target`, with dir_out=1 when the target is above the track register. It changes the track register by one per pulse and stops when the two are equal. If they are equal at the start, no step is issued.
- R6: Step-in (cmd_op=3) sets dir_out=1 and step-out (cmd_op=4) sets dir_out=0. Each issues exactly one pulse. Plain step (cmd_op=2) issues one pulse in the direction already held.
- R7: For step, step-in and step-out, the track register moves by +1 (inward) or -1 (outward) only when cmd_update=1. Otherwise it is unchanged.
- R8: Each step pulse is high for PULSE_MFM_CYC clock cycles when mfm_sel=1 and PULSE_FM_CYC cycles when mfm_sel=0 (defaults 250 and 500, which are 2 us and 4 us at 125 MHz).
- R9: Successive step pulses of one command start RATE_T0/T1/T2/T3 ticks apart for cmd_rate 0/1/2/3 (defaults 6, 12, 20 and 30). The spacing is never shorter than the pulse itself.
- R10: busy is high from the cycle after a command is accepted until completion. At completion busy falls and intrq rises. A `cmd_valid` that arrives while busy is ignored.
- R11: A command with cmd_hload=1 raises hld_out at its start. A command with cmd_hload=0 and cmd_verify=1 raises it when verification begins. A command with both bits 0 drops it.
- R12: While idle with hld_out=1, hld_out drops on the 15th (IDLE_INDEX) rising edge of `index_p`, and not before.
- R13: A low-to-high transition of `mr_n` starts a restore at rate MR_RATE with head load and verify off.
- R14: With cmd_verify=1 and no restore timeout, verify_req stays high after the last step until `verify_done`. The command then ends with seek_err equal to the inverse of `verify_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mr_n | input | 1 | Master reset level; rising edge starts a restore, low aborts |
| cmd_valid | input | 1 | One-cycle command strobe, taken only while idle |
| cmd_op | input | 3 | 0 restore, 1 seek, 2 step, 3 step-in, 4 step-out |
| cmd_rate | input | 2 | Step rate select |
| cmd_hload | input | 1 | Load head at command start |
| cmd_verify | input | 1 | Request track verification after stepping |
| cmd_update | input | 1 | Update the track register on single steps |
| mfm_sel | input | 1 | 1 selects the short (double-density) step pulse |
| tick | input | 1 | Timebase tick for step spacing |
| index_p | input | 1 | Index pulse from the drive |
| trk0_n | input | 1 | Track-zero sensor, active low |
| target | input | TW | Target track for seek |
| trk_wr | input | 1 | Track register write strobe while idle |
| trk_wdata | input | TW | Track register write value |
| verify_done | input | 1 | Verification finished |
| verify_ok | input | 1 | Verification result, 1 = match |
| step_out | output | 1 | Step pulse |
| dir_out | output | 1 | Step direction, 1 = inward |
| hld_out | output | 1 | Head load |
| busy | output | 1 | Command in progress |
| intrq | output | 1 | Completion interrupt |
| seek_err | output | 1 | Seek error flag |
| verify_req | output | 1 | Verification requested |
| track | output | TW | Track register |

## Verification
Seeks run upward, downward and onto the current track. Comparing these shows that direction comes from the target comparison and that the equal case issues no pulse. Single steps are run with the update bit set and clear, and a plain step follows each of step-in and step-out. This separates direction reuse from track update. Restore is run three ways: from an offset head position, with the sensor already active, and with the sensor held inactive. This separates the zeroing path from the 255-step timeout. A command is also presented in the middle of a long seek to confirm it is ignored.

// File: rtl/hss_pkg.sv
package hss_pkg;
  typedef enum logic [2:0] {
    OP_RESTORE  = 3'd0,
    OP_SEEK     = 3'd1,
    OP_STEP     = 3'd2,
    OP_STEP_IN  = 3'd3,
    OP_STEP_OUT = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_CHECK,
    S_WAIT,
    S_VERIFY
  } st_e;
endpackage

// File: rtl/hss_step_pulse.sv
module hss_step_pulse #(
  parameter int MFM_CYC = 250,
  parameter int FM_CYC  = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic kill,
  input  logic mfm,
  output logic step
);
  localparam int LMAX = (MFM_CYC > FM_CYC) ? MFM_CYC : FM_CYC;
  localparam int W    = $clog2(LMAX + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || kill) cnt <= '0;
    else if (fire)      cnt <= mfm ? W'(MFM_CYC) : W'(FM_CYC);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign step = (cnt != '0);

  // R8: a new pulse is never requested while one is still running
  a_r8_no_refire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !step);
endmodule

// File: rtl/hss_rate_timer.sv
module hss_rate_timer #(
  parameter int T0 = 6,
  parameter int T1 = 12,
  parameter int T2 = 20,
  parameter int T3 = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       tick,
  input  logic [1:0] rate,
  output logic       done
);
  localparam int TA   = (T0 > T1) ? T0 : T1;
  localparam int TB   = (T2 > T3) ? T2 : T3;
  localparam int TMAX = (TA > TB) ? TA : TB;
  localparam int W    = $clog2(TMAX + 1);

  logic [W-1:0] lim, cnt;
  logic         running;

  always_comb begin
    case (rate)
      2'd0:    lim = W'(T0);
      2'd1:    lim = W'(T1);
      2'd2:    lim = W'(T2);
      default: lim = W'(T3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (start) begin
      cnt     <= '0;
      running <= 1'b1;
    end else if (running && tick) begin
      cnt <= cnt + 1'b1;
      if (cnt + 1'b1 == lim) running <= 1'b0;
    end
  end

  assign done = !running;

  // R9: the interval never reports expiry in the cycle after it was started
  a_r9_not_early: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);
endmodule

// File: rtl/hss_head_ctl.sv
module hss_head_ctl #(
  parameter int IDLE_INDEX = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic set_req,
  input  logic clr_req,
  input  logic index_p,
  output logic hld
);
  localparam int W = $clog2(IDLE_INDEX + 1);

  logic [W-1:0] cnt;
  logic         idx_prev;
  logic         idx_rise;

  assign idx_rise = index_p && !idx_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hld      <= 1'b0;
      cnt      <= '0;
      idx_prev <= 1'b0;
    end else begin
      idx_prev <= index_p;
      if (set_req) begin
        hld <= 1'b1;
        cnt <= '0;
      end else if (clr_req) begin
        hld <= 1'b0;
        cnt <= '0;
      end else if (busy || !hld) begin
        cnt <= '0;
      end else if (idx_rise) begin
        if (cnt == W'(IDLE_INDEX - 1)) begin
          hld <= 1'b0;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R11/R12: head load falls only on an explicit drop or while idle
  a_r12_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hld) |-> ($past(clr_req) || !$past(busy)));
endmodule

// File: rtl/head_step_seq.sv
module head_step_seq #(
  parameter int         TW            = 8,
  parameter int         PULSE_MFM_CYC = 250,
  parameter int         PULSE_FM_CYC  = 500,
  parameter int         RATE_T0       = 6,
  parameter int         RATE_T1       = 12,
  parameter int         RATE_T2       = 20,
  parameter int         RATE_T3       = 30,
  parameter int         IDLE_INDEX    = 15,
  parameter int         MAX_RESTORE   = 255,
  parameter logic [1:0] MR_RATE       = 2'd3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mr_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [1:0]    cmd_rate,
  input  logic          cmd_hload,
  input  logic          cmd_verify,
  input  logic          cmd_update,
  input  logic          mfm_sel,
  input  logic          tick,
  input  logic          index_p,
  input  logic          trk0_n,
  input  logic [TW-1:0] target,
  input  logic          trk_wr,
  input  logic [TW-1:0] trk_wdata,
  input  logic          verify_done,
  input  logic          verify_ok,
  output logic          step_out,
  output logic          dir_out,
  output logic          hld_out,
  output logic          busy,
  output logic          intrq,
  output logic          seek_err,
  output logic          verify_req,
  output logic [TW-1:0] track
);
  import hss_pkg::*;

  localparam int CW = $clog2(MAX_RESTORE + 1);

  st_e           st;
  op_e           op_q, start_op;
  logic [1:0]    rate_q, start_rate;
  logic          h_q, v_q, u_q, start_h, start_v, start_u;
  logic          dir_q, err_q, irq_q, mr_prev;
  logic [TW-1:0] trk_q, trk_nx;
  logic          dir_nx;
  logic [CW-1:0] nsteps;
  logic          mr_rise, start, fire, fin, fail;
  logic          tmr_done, hset, hclr;

  assign mr_rise = mr_n && !mr_prev;
  assign start   = mr_rise || (cmd_valid && mr_n && (st == S_IDLE));

  always_comb begin
    if (mr_rise) begin
      start_op   = OP_RESTORE;
      start_rate = MR_RATE;
      start_h    = 1'b0;
      start_v    = 1'b0;
      start_u    = 1'b0;
    end else begin
      start_op   = op_e'(cmd_op);
      start_rate = cmd_rate;
      start_h    = cmd_hload;
      start_v    = cmd_verify;
      start_u    = cmd_update;
    end
  end

  // per-visit decision: stop, fail or issue one more pulse
  always_comb begin
    fire   = 1'b0;
    fin    = 1'b0;
    fail   = 1'b0;
    trk_nx = trk_q;
    dir_nx = dir_q;
    if (st == S_CHECK) begin
      case (op_q)
        OP_RESTORE: begin
          if (!trk0_n) begin
            fin    = 1'b1;
            trk_nx = '0;
          end else if (nsteps == CW'(MAX_RESTORE)) begin
            fin  = 1'b1;
            fail = 1'b1;
          end else begin
            fire   = 1'b1;
            dir_nx = 1'b0;
          end
        end
        OP_SEEK: begin
          if (trk_q == target) begin
            fin = 1'b1;
          end else begin
            fire   = 1'b1;
            dir_nx = (target > trk_q);
            trk_nx = (target > trk_q) ? trk_q + 1'b1 : trk_q - 1'b1;
          end
        end
        default: begin
          if (nsteps != '0) begin
            fin = 1'b1;
          end else begin
            fire = 1'b1;
            if (u_q) trk_nx = dir_q ? trk_q + 1'b1 : trk_q - 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= OP_RESTORE;
      rate_q  <= 2'd0;
      h_q     <= 1'b0;
      v_q     <= 1'b0;
      u_q     <= 1'b0;
      dir_q   <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      mr_prev <= 1'b1;
      trk_q   <= '0;
      nsteps  <= '0;
    end else begin
      mr_prev <= mr_n;
      if (!mr_n) begin
        st <= S_IDLE;
      end else if (start) begin
        op_q   <= start_op;
        rate_q <= start_rate;
        h_q    <= start_h;
        v_q    <= start_v;
        u_q    <= start_u;
        nsteps <= '0;
        err_q  <= 1'b0;
        irq_q  <= 1'b0;
        st     <= S_CHECK;
        if (start_op == OP_STEP_IN) dir_q <= 1'b1;
        else if (start_op == OP_STEP_OUT || start_op == OP_RESTORE) dir_q <= 1'b0;
      end else begin
        case (st)
          S_IDLE: begin
            if (trk_wr) trk_q <= trk_wdata;
          end
          S_CHECK: begin
            trk_q <= trk_nx;
            dir_q <= dir_nx;
            if (fire) begin
              nsteps <= nsteps + 1'b1;
              st     <= S_WAIT;
            end else if (fin) begin
              if (fail) err_q <= 1'b1;
              if (v_q && !fail) begin
                st <= S_VERIFY;
              end else begin
                st    <= S_IDLE;
                irq_q <= 1'b1;
              end
            end
          end
          S_WAIT: begin
            if (tmr_done && !step_out) st <= S_CHECK;
          end
          S_VERIFY: begin
            if (verify_done) begin
              err_q <= !verify_ok;
              irq_q <= 1'b1;
              st    <= S_IDLE;
            end
          end
        endcase
      end
    end
  end

  assign hset = (start && start_h) ||
                ((st == S_CHECK) && fin && !fail && v_q && !h_q);
  assign hclr = start && !start_h && !start_v;

  hss_step_pulse #(
    .MFM_CYC (PULSE_MFM_CYC),
    .FM_CYC  (PULSE_FM_CYC)
  ) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .kill  (!mr_n),
    .mfm   (mfm_sel),
    .step  (step_out)
  );

  hss_rate_timer #(
    .T0 (RATE_T0),
    .T1 (RATE_T1),
    .T2 (RATE_T2),
    .T3 (RATE_T3)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (fire),
    .tick  (tick),
    .rate  (rate_q),
    .done  (tmr_done)
  );

  hss_head_ctl #(
    .IDLE_INDEX (IDLE_INDEX)
  ) u_head (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .set_req (hset),
    .clr_req (hclr),
    .index_p (index_p),
    .hld     (hld_out)
  );

  assign busy       = (st != S_IDLE);
  assign intrq      = irq_q;
  assign seek_err   = err_q;
  assign dir_out    = dir_q;
  assign track      = trk_q;
  assign verify_req = (st == S_VERIFY);

  // R10: the interrupt is only ever seen with the block idle
  a_r10_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    intrq |-> !busy);

  // R6: direction never moves while a pulse is in flight
  a_r6_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step_out && $past(step_out)) |-> $stable(dir_out));

  // R7: during a command the track register moves by one or is zeroed
  a_r7_track_delta: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (track != $past(track))) |->
      ((track == $past(track) + 1'b1) || (track == $past(track) - 1'b1) || (track == '0)));
endmodule

// File: tb/tb_head_step_seq.sv
module tb_head_step_seq;
  localparam int TP = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mr_n = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] cmd_rate = 2'd0;
  logic       cmd_hload = 1'b0, cmd_verify = 1'b0, cmd_update = 1'b0;
  logic       mfm_sel = 1'b1;
  logic       tick = 1'b0;
  logic       index_p = 1'b0;
  logic       trk0_n;
  logic [7:0] target = 8'd0;
  logic       trk_wr = 1'b0;
  logic [7:0] trk_wdata = 8'd0;
  logic       verify_done = 1'b0, verify_ok = 1'b1;
  logic       step_out, dir_out, hld_out, busy, intrq, seek_err, verify_req;
  logic [7:0] track;

  head_step_seq dut (
    .clk(clk), .rst_n(rst_n), .mr_n(mr_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_rate(cmd_rate), .cmd_hload(cmd_hload),
    .cmd_verify(cmd_verify), .cmd_update(cmd_update), .mfm_sel(mfm_sel),
    .tick(tick), .index_p(index_p), .trk0_n(trk0_n), .target(target),
    .trk_wr(trk_wr), .trk_wdata(trk_wdata), .verify_done(verify_done),
    .verify_ok(verify_ok), .step_out(step_out), .dir_out(dir_out),
    .hld_out(hld_out), .busy(busy), .intrq(intrq), .seek_err(seek_err),
    .verify_req(verify_req), .track(track)
  );

  always #4 clk = ~clk;

  typedef struct {
    int    trk;
    int    err;
    int    pulses;
    int    dir;
    int    width;
    int    rate;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  int done_cnt = 0, exp_done = 0;
  int pos = 3;
  bit no_zero = 1'b0;
  int vcount = 0;
  bit finished = 1'b0;

  assign trk0_n = no_zero || (pos != 0);

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int rate_ticks(input int r);
    case (r)
      0: return 6;
      1: return 12;
      2: return 20;
      default: return 30;
    endcase
  endfunction

  // timebase
  initial forever begin
    repeat (TP - 1) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  end

  // verification responder
  initial forever begin
    @(negedge clk);
    if (verify_req) begin
      vcount++;
      chk(hld_out == 1'b1, "R11 head load at verify", hld_out, 1);
      repeat (10) @(negedge clk);
      verify_done = 1'b1;
      @(negedge clk);
      verify_done = 1'b0;
    end
  end

  // monitor: pulses, head model and scoreboard compare
  initial begin
    int  cyc = 0, npul = 0, last_rise = 0, spacing = 0, width = 0;
    bit  pstep = 1'b0, pirq = 1'b0;
    item_t it;
    forever begin
      @(negedge clk);
      cyc++;
      if (step_out && !pstep) begin
        if (npul > 0) spacing = cyc - last_rise;
        last_rise = cyc;
        npul++;
        pos += dir_out ? 1 : -1;
        if (pos < 0) pos = 0;
      end
      if (!step_out && pstep) width = cyc - last_rise;
      if (intrq && !pirq) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10 unexpected interrupt", 1, 0);
        end else begin
          it = q.pop_front();
          chk(busy == 1'b0, {it.tag, " R10 busy low at interrupt"}, busy, 0);
          chk(int'(track) == it.trk, {it.tag, " track"}, track, it.trk);
          chk(int'(seek_err) == it.err, {it.tag, " seek_err"}, seek_err, it.err);
          chk(npul == it.pulses, {it.tag, " pulse count"}, npul, it.pulses);
          chk(int'(dir_out) == it.dir, {it.tag, " direction"}, dir_out, it.dir);
          if (it.width > 0)
            chk(width == it.width, {it.tag, " R8 pulse width"}, width, it.width);
          if (it.rate >= 0 && npul > 1)
            chk(spacing >= (rate_ticks(it.rate) - 1) * TP &&
                spacing <= rate_ticks(it.rate) * TP + 6,
                {it.tag, " R9 step spacing"}, spacing, rate_ticks(it.rate) * TP);
        end
        npul = 0;
        spacing = 0;
        done_cnt++;
      end
      pstep = step_out;
      pirq  = intrq;
    end
  end

  task automatic push(input int trk, input int err, input int p, input int d,
                      input int w, input int r, input string tag);
    item_t it;
    it.trk = trk; it.err = err; it.pulses = p; it.dir = d;
    it.width = w; it.rate = r; it.tag = tag;
    q.push_back(it);
    exp_done++;
  endtask

  task automatic issue(input int op, input int rate, input bit h, input bit v,
                       input bit u, input int tgt, input bit m);
    @(negedge clk);
    cmd_op = op[2:0]; cmd_rate = rate[1:0]; cmd_hload = h; cmd_verify = v;
    cmd_update = u; target = tgt[7:0]; mfm_sel = m; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    wait (done_cnt >= exp_done);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && intrq == 0 && step_out == 0 && verify_req == 0, "R1 control outputs", busy, 0);
    chk(hld_out == 0 && dir_out == 0 && seek_err == 0, "R1 head/dir/err", hld_out, 0);
    chk(track == 8'd0, "R1 track", track, 0);

    // R13 + R3: master reset edge restores from track 3
    mr_n = 1'b0;
    repeat (5) @(negedge clk);
    push(0, 0, 3, 0, 250, 3, "R13 R3 restore");
    mr_n = 1'b1;
    wait_done();

    // R2: restore already at track zero
    push(0, 0, 0, 0, 0, -1, "R2 restore at zero");
    issue(0, 1, 0, 0, 0, 0, 1);
    wait_done();

    // R5: seek upward, FM pulse
    push(5, 0, 5, 1, 500, 1, "R5 seek up");
    issue(1, 1, 0, 0, 0, 5, 0);
    wait_done();
    push(5, 0, 0, 1, 0, -1, "R5 seek equal");
    issue(1, 1, 0, 0, 0, 5, 1);
    wait_done();
    push(2, 0, 3, 0, 250, 2, "R5 seek down");
    issue(1, 2, 0, 0, 0, 2, 1);
    wait_done();

    // R6 R7: single steps
    push(3, 0, 1, 1, 250, -1, "R6 R7 step-in update");
    issue(3, 0, 0, 0, 1, 2, 1);
    wait_done();
    push(3, 0, 1, 0, 250, -1, "R6 R7 step-out no update");
    issue(4, 0, 0, 0, 0, 2, 1);
    wait_done();
    push(2, 0, 1, 0, 250, -1, "R6 plain step reuses out");
    issue(2, 0, 0, 0, 1, 2, 1);
    wait_done();
    push(2, 0, 1, 1, 250, -1, "R7 step-in no update");
    issue(3, 0, 0, 0, 0, 2, 1);
    wait_done();
    push(3, 0, 1, 1, 250, -1, "R6 plain step reuses in");
    issue(2, 0, 0, 0, 1, 2, 1);
    wait_done();

    // R11 R14: verify with h=0, pass
    verify_ok = 1'b1;
    push(4, 0, 1, 1, 250, -1, "R14 verify pass");
    issue(3, 0, 0, 1, 1, 2, 1);
    chk(hld_out == 1'b0, "R11 head stays off before verify", hld_out, 0);
    wait_done();
    chk(vcount == 1, "R14 verify requested", vcount, 1);

    // R11 R14: h=1 verify fail
    verify_ok = 1'b0;
    push(6, 1, 2, 1, 250, 1, "R14 verify fail");
    issue(1, 1, 1, 1, 0, 6, 1);
    chk(hld_out == 1'b1, "R11 head load at start", hld_out, 1);
    wait_done();
    verify_ok = 1'b1;

    // R12: idle release on 15th index
    for (int i = 0; i < 14; i++) begin
      @(negedge clk); index_p = 1'b1;
      @(negedge clk); index_p = 1'b0;
      repeat (3) @(negedge clk);
    end
    chk(hld_out == 1'b1, "R12 head held after 14 index", hld_out, 1);
    @(negedge clk); index_p = 1'b1;
    @(negedge clk); index_p = 1'b0;
    repeat (3) @(negedge clk);
    chk(hld_out == 1'b0, "R12 head released at 15th index", hld_out, 0);

    // R10: command while busy is ignored
    push(10, 0, 4, 1, 250, 3, "R10 ignore while busy");
    issue(1, 3, 0, 0, 0, 10, 1);
    repeat (100) @(negedge clk);
    chk(busy == 1'b1, "R10 busy mid command", busy, 1);
    cmd_op = 3'd3; cmd_update = 1'b1; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();

    // R1: idle track load, then R4 restore timeout
    trk_wr = 1'b1; trk_wdata = 8'd20;
    @(negedge clk);
    trk_wr = 1'b0;
    @(negedge clk);
    chk(track == 8'd20, "R1 idle track load", track, 20);
    no_zero = 1'b1;
    push(20, 1, 255, 0, 250, -1, "R4 restore timeout");
    issue(0, 0, 0, 0, 0, 0, 1);
    wait_done();
    no_zero = 1'b0;
    push(0, 0, 0, 0, 0, -1, "R2 restore after timeout");
    issue(0, 0, 0, 0, 0, 0, 1);
    wait_done();

    summary();
  end
endmodule